// File: doc/BRIEF.md
# Auto-Delayed Compare Unit

This block produces the second compare-match pulse of a timing unit whose counter runs freely. In its plain mode the programmed threshold is always live and a pulse appears whenever the counter reaches it. In its three delayed modes the comparator stays dormant until a trigger arrives. When a capture strobe is the trigger, the threshold is rebuilt as the captured counter value plus the programmed offset. Depending on the mode, a first-compare or third-compare match can act instead as a timeout trigger, and the threshold is then built from that compare's value plus the offset.

A delayed threshold fires once and is then disarmed. Each new counter period also disarms it, so every period needs a fresh trigger. The mode is sampled only while the counter is stopped. The counter, the capture logic and any register access lie outside the block, which only reacts to the strobes it is given.

Top module: `delayed_cmp_unit`

## Requirements
- R1: With mode code 0 (plain), `armed` is 1, `thr_out` equals `cmp2_val`, and one match pulse appears each time the counter passes the programmed value.
- R2: With mode code 1, the unit is disarmed until a `cap_stb` cycle. After that cycle, `thr_out` equals `cap_val + cmp2_val` modulo 2^W and `armed` is 1.
- R3: With mode code 2, a `cmp1_stb` cycle without a capture arms the unit with `thr_out = cmp1_val + cmp2_val` modulo 2^W.
- R4: With mode code 3, a `cmp3_stb` cycle arms the unit with `thr_out = cmp3_val + cmp2_val`. `cmp1_stb` has no effect in mode 3, and `cmp3_stb` has no effect in mode 2.
- R5: If a capture and a timeout strobe arrive in the same cycle, the captured value is used.
- R6: In modes 1 to 3, the unit disarms in the cycle after its comparator fires, so one trigger gives at most one pulse.
- R7: In modes 1 to 3, a `period_start` cycle with no trigger disarms the unit, and an armed threshold that is not reached in that period never fires.
- R8: `mode_in` is taken into the unit only while `cnt_en` is 0, and it takes effect one cycle later. A change while `cnt_en` is 1 is ignored.
- R9: `match_pulse` is high for one cycle, in the cycle after a cycle where `cnt_en`, `armed` and `cnt_val == thr_out` all hold. It is never high in the cycle after `cnt_en` is 0.
- R10: After synchronous reset the mode is 0 (plain) and `match_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter running flag |
| cnt_val | input | W | Current counter value |
| period_start | input | 1 | Counter reset or roll-over cycle |
| mode_in | input | 2 | Requested mode: 0 plain, 1 capture, 2 capture or cmp1 timeout, 3 capture or cmp3 timeout |
| cmp2_val | input | W | Programmed compare-2 value or offset |
| cap_stb | input | 1 | Capture event strobe |
| cap_val | input | W | Captured counter value |
| cmp1_stb | input | 1 | Compare-1 match strobe |
| cmp1_val | input | W | Compare-1 value |
| cmp3_stb | input | 1 | Compare-3 match strobe |
| cmp3_val | input | W | Compare-3 value |
| thr_out | output | W | Effective compare-2 threshold |
| armed | output | 1 | Comparator armed |
| match_pulse | output | 1 | Registered compare-2 match pulse |

## Verification
The bench builds the unit with W = 8 and drives it from its own counter with a period of 100. At this width a captured value near the top of the range plus the offset wraps modulo 256. The period is short enough that a rebuilt threshold can land past the roll-over, which lets the bench check that the roll-over disarms the unit. Each mode is run over whole periods, with strobes placed at known counter values, so the position and number of match pulses can be predicted exactly.

// File: rtl/delayed_cmp_pkg.sv
package delayed_cmp_pkg;
  typedef enum logic [1:0] {
    DC_PLAIN  = 2'd0,
    DC_CAP    = 2'd1,
    DC_CAP_T1 = 2'd2,
    DC_CAP_T3 = 2'd3
  } dc_mode_e;
endpackage

// File: rtl/dc_mode_reg.sv
module dc_mode_reg
  import delayed_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cnt_en,
  input  logic [1:0] mode_in,
  output dc_mode_e   mode_q
);
  always_ff @(posedge clk) begin
    if (rst)
      mode_q <= DC_PLAIN;
    else if (!cnt_en)
      mode_q <= dc_mode_e'(mode_in);
  end
endmodule

// File: rtl/dc_arm_ctrl.sv
module dc_arm_ctrl
  import delayed_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  dc_mode_e     mode,
  input  logic         period_start,
  input  logic         fire,
  input  logic [W-1:0] cmp2_val,
  input  logic         cap_stb,
  input  logic [W-1:0] cap_val,
  input  logic         cmp1_stb,
  input  logic [W-1:0] cmp1_val,
  input  logic         cmp3_stb,
  input  logic [W-1:0] cmp3_val,
  output logic [W-1:0] thr,
  output logic         armed
);
  logic         tmo_hit;
  logic [W-1:0] tmo_val;
  logic         trig;
  logic [W-1:0] base;
  logic         arm_q;
  logic [W-1:0] thr_q;

  // timeout source picked by mode
  always_comb begin
    tmo_hit = 1'b0;
    tmo_val = cmp1_val;
    unique case (mode)
      DC_CAP_T1: begin tmo_hit = cmp1_stb; tmo_val = cmp1_val; end
      DC_CAP_T3: begin tmo_hit = cmp3_stb; tmo_val = cmp3_val; end
      default:   begin tmo_hit = 1'b0;     tmo_val = cmp1_val; end
    endcase
    trig = cap_stb | tmo_hit;
    base = cap_stb ? cap_val : tmo_val;  // capture wins
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
      thr_q <= '0;
    end else if (!cnt_en || mode == DC_PLAIN) begin
      arm_q <= 1'b0;
    end else if (trig) begin
      arm_q <= 1'b1;
      thr_q <= base + cmp2_val;
    end else if (period_start || fire) begin
      arm_q <= 1'b0;
    end
  end

  assign armed = (mode == DC_PLAIN) | arm_q;
  assign thr   = (mode == DC_PLAIN) ? cmp2_val : thr_q;
endmodule

// File: rtl/dc_match.sv
module dc_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic         armed,
  input  logic [W-1:0] cnt_val,
  input  logic [W-1:0] thr,
  output logic         fire,
  output logic         match_q
);
  assign fire = cnt_en & armed & (cnt_val == thr);

  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b0;
    else     match_q <= fire;
  end
endmodule

// File: rtl/delayed_cmp_unit.sv
module delayed_cmp_unit
  import delayed_cmp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_en,
  input  logic [W-1:0] cnt_val,
  input  logic         period_start,
  input  logic [1:0]   mode_in,
  input  logic [W-1:0] cmp2_val,
  input  logic         cap_stb,
  input  logic [W-1:0] cap_val,
  input  logic         cmp1_stb,
  input  logic [W-1:0] cmp1_val,
  input  logic         cmp3_stb,
  input  logic [W-1:0] cmp3_val,
  output logic [W-1:0] thr_out,
  output logic         armed,
  output logic         match_pulse
);
  dc_mode_e mode_q;
  logic     fire;

  dc_mode_reg i_mode (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode_in(mode_in), .mode_q(mode_q)
  );

  dc_arm_ctrl #(.W(W)) i_arm (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .mode(mode_q),
    .period_start(period_start), .fire(fire), .cmp2_val(cmp2_val),
    .cap_stb(cap_stb), .cap_val(cap_val),
    .cmp1_stb(cmp1_stb), .cmp1_val(cmp1_val),
    .cmp3_stb(cmp3_stb), .cmp3_val(cmp3_val),
    .thr(thr_out), .armed(armed)
  );

  dc_match #(.W(W)) i_match (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .armed(armed),
    .cnt_val(cnt_val), .thr(thr_out), .fire(fire), .match_q(match_pulse)
  );
endmodule

// File: rtl/delayed_cmp_chk.sv
module delayed_cmp_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic [W-1:0] cnt_val,
  input logic [W-1:0] cmp2_val,
  input logic         cap_stb,
  input logic [W-1:0] cap_val,
  input logic         cmp1_stb,
  input logic         cmp3_stb,
  input logic [W-1:0] thr_out,
  input logic         armed,
  input logic         match_pulse,
  input logic [1:0]   mode_q
);
  logic [W-1:0] sum_cap;
  logic         tmo;
  assign sum_cap = cap_val + cmp2_val;
  assign tmo = (mode_q == 2'd2 && cmp1_stb) || (mode_q == 2'd3 && cmp3_stb);

  // R1
  plain_live_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0) |-> (armed && thr_out == cmp2_val));

  // R2
  cap_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'd0 && cnt_en && cap_stb) |=> (armed && thr_out == $past(sum_cap)));

  // R6
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q != 2'd0 && cnt_en && armed && cnt_val == thr_out && !cap_stb && !tmo)
    |=> !armed);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> $stable(mode_q));

  // R9
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(cnt_en && armed && cnt_val == thr_out));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> !match_pulse);
endmodule

bind delayed_cmp_unit delayed_cmp_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_val(cnt_val),
  .cmp2_val(cmp2_val), .cap_stb(cap_stb), .cap_val(cap_val),
  .cmp1_stb(cmp1_stb), .cmp3_stb(cmp3_stb), .thr_out(thr_out),
  .armed(armed), .match_pulse(match_pulse), .mode_q(mode_q)
);

// File: tb/test_delayed_cmp_unit.sv
module test_delayed_cmp_unit;
  localparam int W   = 8;
  localparam int PER = 100;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cnt_en = 1'b0;
  logic [W-1:0] cnt_val;
  logic         period_start;
  logic [1:0]   mode_in = 2'd0;
  logic [W-1:0] cmp2_val = '0;
  logic         cap_stb = 1'b0;
  logic [W-1:0] cap_val = '0;
  logic         cmp1_stb = 1'b0;
  logic [W-1:0] cmp1_val = '0;
  logic         cmp3_stb = 1'b0;
  logic [W-1:0] cmp3_val = '0;
  logic [W-1:0] thr_out;
  logic         armed;
  logic         match_pulse;

  int checks = 0;
  int fails  = 0;
  int npulse = 0;
  int ppos   = -1;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst || !cnt_en) cnt_val <= '0;
    else if (cnt_val == W'(PER - 1)) cnt_val <= '0;
    else cnt_val <= cnt_val + 1'b1;
  end
  assign period_start = cnt_en && (cnt_val == '0);

  delayed_cmp_unit #(.W(W)) i_delayed_cmp_unit (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_val(cnt_val),
    .period_start(period_start), .mode_in(mode_in), .cmp2_val(cmp2_val),
    .cap_stb(cap_stb), .cap_val(cap_val), .cmp1_stb(cmp1_stb),
    .cmp1_val(cmp1_val), .cmp3_stb(cmp3_stb), .cmp3_val(cmp3_val),
    .thr_out(thr_out), .armed(armed), .match_pulse(match_pulse)
  );

  always @(negedge clk) begin
    if (match_pulse) begin
      npulse++;
      ppos = (cnt_val == '0) ? PER - 1 : int'(cnt_val) - 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (int'(cnt_val) != v);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cnt_en = 1'b0;
    mode_in = m;
    repeat (2) @(negedge clk);
    cnt_en = 1'b1;
    npulse = 0;
    ppos = -1;
  endtask

  task automatic strobe_at(input int v, input bit c, input bit t1, input bit t3,
                           input int cv, input int v1, input int v3);
    wait_cnt(v);
    cap_stb = c;  cap_val = W'(cv);
    cmp1_stb = t1; cmp1_val = W'(v1);
    cmp3_stb = t3; cmp3_val = W'(v3);
    @(negedge clk);
    cap_stb = 1'b0; cmp1_stb = 1'b0; cmp3_stb = 1'b0;
  endtask

  task automatic t_reset();
    cmp2_val = 8'd30;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(match_pulse == 1'b0, "R10 match after reset", match_pulse, 0);
    check(armed == 1'b1, "R10 plain mode after reset", armed, 1);
  endtask

  task automatic t_plain();
    set_mode(2'd0);
    @(negedge clk);
    check(thr_out == 8'd30, "R1 threshold", thr_out, 30);
    repeat (2 * PER) @(negedge clk);
    check(npulse == 2, "R1 pulses over two periods", npulse, 2);
    check(ppos == 30, "R1 pulse position", ppos, 30);
  endtask

  task automatic t_capture();
    cmp2_val = 8'd20;
    set_mode(2'd1);
    wait_cnt(5);
    check(armed == 1'b0, "R2 idle before capture", armed, 0);
    strobe_at(10, 1, 0, 0, 10, 0, 0);
    check(thr_out == 8'd30, "R2 rebuilt threshold", thr_out, 30);
    check(armed == 1'b1, "R2 armed after capture", armed, 1);
    wait_cnt(50);
    check(npulse == 1, "R6 single pulse", npulse, 1);
    check(ppos == 30, "R9 pulse position", ppos, 30);
    check(armed == 1'b0, "R6 disarmed after firing", armed, 0);
    strobe_at(60, 1, 0, 0, 250, 0, 0);
    check(thr_out == 8'd14, "R2 modulo sum", thr_out, 14);
    wait_cnt(1);
    check(armed == 1'b0, "R7 disarmed at roll-over", armed, 0);
    wait_cnt(40);
    check(npulse == 1, "R7 stale threshold never fires", npulse, 1);
  endtask

  task automatic t_tmo1();
    set_mode(2'd2);
    strobe_at(5, 0, 0, 1, 0, 0, 7);
    check(armed == 1'b0, "R4 cmp3 ignored in mode 2", armed, 0);
    strobe_at(40, 0, 1, 0, 0, 40, 0);
    check(thr_out == 8'd60, "R3 timeout threshold", thr_out, 60);
    wait_cnt(80);
    check(npulse == 1 && ppos == 60, "R3 timeout pulse", ppos, 60);
  endtask

  task automatic t_tmo3();
    set_mode(2'd3);
    strobe_at(5, 0, 1, 0, 0, 9, 0);
    check(armed == 1'b0, "R4 cmp1 ignored in mode 3", armed, 0);
    strobe_at(10, 0, 0, 1, 0, 0, 10);
    check(thr_out == 8'd30, "R4 cmp3 threshold", thr_out, 30);
    wait_cnt(50);
    check(npulse == 1 && ppos == 30, "R4 cmp3 pulse", ppos, 30);
    strobe_at(55, 1, 0, 1, 55, 0, 70);
    check(thr_out == 8'd75, "R5 capture priority", thr_out, 75);
    wait_cnt(90);
    check(npulse == 2 && ppos == 75, "R5 pulse from capture", ppos, 75);
  endtask

  task automatic t_lock();
    mode_in = 2'd0;
    repeat (5) @(negedge clk);
    check(armed == 1'b0, "R8 mode change ignored while enabled", armed, 0);
    cmp2_val = 8'd0;
    @(negedge clk);
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    check(armed == 1'b1 && thr_out == 8'd0, "R8 mode taken while stopped", armed, 1);
    npulse = 0;
    repeat (5) @(negedge clk);
    check(npulse == 0, "R9 no pulse while stopped", npulse, 0);
  endtask

  initial begin
    t_reset();
    t_plain();
    t_capture();
    t_tmo1();
    t_tmo3();
    t_lock();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule